// File: doc/BRIEF.md
# Interrupt Request Capture

This block turns a set of raw interrupt request lines into a clean, clocked request vector for a controller. Every channel passes through an input synchronizer and then, depending on a per-channel bypass bit, either through a capture latch or straight to a common output register. The registered vector drives the rest of the system, and an OR of that vector gives a single any-request line that a controller can test before deciding which channel to serve.

A channel in catch mode suits sources that emit short transient pulses. The first rising edge sets the capture latch, and the latch then holds the request until that channel's acknowledge clears it. Further pulses on a channel that is already captured merge into the pending request. A channel in level mode suits devices that keep their line asserted until they are served. The output follows the synchronized line, and the device itself removes the request.

Top module: `irqCapture`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears the synchronizer, the capture latches and the output register. `reqOut` and `anyReq` read zero on the edge after reset is sampled.
- R2: A channel with `bypass` = 1 is in level mode. Its `reqOut` bit equals the value the request line had when it was sampled SYNC_STAGES rising edges earlier, and its `ack` bit has no effect.
- R3: A channel with `bypass` = 0 is in catch mode. A rising edge on its request line, even one only a single clock period wide, sets its `reqOut` bit SYNC_STAGES+1 rising edges after the edge that samples it. The bit stays set after the line falls.
- R4: In catch mode, further pulses on a channel that is already captured add no request. One acknowledge clears the pending request, and `reqOut` then stays low.
- R5: In catch mode, `ack` high at a rising edge clears the capture latch. The `reqOut` bit falls on the next rising edge.
- R6: In catch mode, if a new rising edge reaches the capture latch in the same cycle as that channel's `ack`, the request stays set.
- R7: While `bypass` = 1 the channel's capture latch is held clear. Returning the channel to catch mode shows no stale request from before the switch.
- R8: `anyReq` is high exactly when at least one bit of `reqOut` is high, in the same cycle.
- R9: Channels are independent. The mode, line and acknowledge of one channel never change another channel's `reqOut` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reqIn | input | NUM_CH | Raw request lines, one per channel |
| bypass | input | NUM_CH | Per-channel mode: 1 = level, 0 = catch pulses |
| ack | input | NUM_CH | Per-channel acknowledge, clears a caught request |
| reqOut | output | NUM_CH | Registered request vector |
| anyReq | output | 1 | OR of all bits of `reqOut` |

## Verification
The bench builds the block with eight channels and a two-stage synchronizer. This gives exact latencies of two and three edges, so the bench can place an acknowledge on the very cycle in which a fresh edge reaches a capture latch. With eight channels it can keep catch and level channels active side by side, mode switches included, so cross-channel interference and the any-request OR are exercised with many patterns.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;

  // Mode encoding of one bypass bit.
  typedef enum logic {
    MODE_CATCH = 1'b0,
    MODE_LEVEL = 1'b1
  } chMode_e;

  // Strobes passed from the control to the datapath for one channel.
  typedef struct packed {
    logic setCap;    // a fresh rising edge seen in catch mode
    logic clrCap;    // acknowledge in catch mode
    logic selLevel;  // channel passes the synchronized level
  } chStrobe_t;

endpackage

// File: rtl/irqcap_sync.sv
module irqcap_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= dIn;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : gStage
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign dOut = stage[LAST];

endmodule

// File: rtl/irqcap_ctrl.sv
module irqcap_ctrl
  import irqcap_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        syncReq,
  input  logic [NUM_CH-1:0]        bypass,
  input  logic [NUM_CH-1:0]        ack,
  output chStrobe_t [NUM_CH-1:0]   strobes
);

  logic [NUM_CH-1:0] prevReq;

  always_ff @(posedge clk) begin
    if (rst) prevReq <= '0;
    else     prevReq <= syncReq;
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : gCh
      chMode_e mode;
      assign mode = chMode_e'(bypass[c]);

      always_comb begin
        strobes[c].selLevel = (mode == MODE_LEVEL);
        strobes[c].setCap   = (mode == MODE_CATCH) && syncReq[c] && !prevReq[c];
        strobes[c].clrCap   = (mode == MODE_CATCH) && ack[c];
      end

      // A set strobe comes from a rising edge, so it cannot repeat back to back.
      AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        strobes[c].setCap |=> !strobes[c].setCap); // R4
    end
  endgenerate

endmodule

// File: rtl/irqcap_datapath.sv
module irqcap_datapath
  import irqcap_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  chStrobe_t [NUM_CH-1:0]   strobes,
  input  logic [NUM_CH-1:0]        levelIn,
  output logic [NUM_CH-1:0]        reqOut,
  output logic                     anyReq
);

  logic [NUM_CH-1:0] captured;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : gCh
      // Capture latch: a new edge has priority over the acknowledge.
      always_ff @(posedge clk) begin
        if (rst || strobes[c].selLevel) captured[c] <= 1'b0;
        else if (strobes[c].setCap)     captured[c] <= 1'b1;
        else if (strobes[c].clrCap)     captured[c] <= 1'b0;
      end

      // Common output register, fed by the latch or by the level.
      always_ff @(posedge clk) begin
        if (rst)                        reqOut[c] <= 1'b0;
        else if (strobes[c].selLevel)   reqOut[c] <= levelIn[c];
        else                            reqOut[c] <= captured[c];
      end

      AST_CATCH_SET: assert property (@(posedge clk) disable iff (rst)
        strobes[c].setCap |=> captured[c]); // R3
      AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (strobes[c].clrCap && !strobes[c].setCap) |=> !captured[c]); // R5
      AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
        (strobes[c].clrCap && strobes[c].setCap) |=> captured[c]); // R6
      AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
        strobes[c].selLevel |=> !captured[c]); // R7
      AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        strobes[c].selLevel |=> (reqOut[c] == $past(levelIn[c]))); // R2
      AST_CATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!strobes[c].selLevel && captured[c] && !strobes[c].clrCap) |=> captured[c]); // R4
    end
  endgenerate

  assign anyReq = |reqOut;

endmodule

// File: rtl/irqCapture.sv
module irqCapture
  import irqcap_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic [NUM_CH-1:0] bypass,
  input  logic [NUM_CH-1:0] ack,
  output logic [NUM_CH-1:0] reqOut,
  output logic              anyReq
);

  localparam int STAGES_USED = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [NUM_CH-1:0]      syncReq;
  chStrobe_t [NUM_CH-1:0] strobes;

  irqcap_sync #(.WIDTH(NUM_CH), .STAGES(STAGES_USED)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .dIn  (reqIn),
    .dOut (syncReq)
  );

  irqcap_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .syncReq (syncReq),
    .bypass  (bypass),
    .ack     (ack),
    .strobes (strobes)
  );

  irqcap_datapath #(.NUM_CH(NUM_CH)) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .levelIn (syncReq),
    .reqOut  (reqOut),
    .anyReq  (anyReq)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (reqOut == '0 && !anyReq)); // R1
  AST_ANY_SET: assert property (@(posedge clk) disable iff (rst)
    (reqOut != '0) |-> anyReq); // R8
  AST_ANY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (reqOut == '0) |-> !anyReq); // R8

endmodule

// File: tb/test_irqCapture.sv
module test_irqCapture;

  localparam int NUM_CH      = 8;
  localparam int SYNC_STAGES = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CH-1:0] reqIn  = '0;
  logic [NUM_CH-1:0] bypass = '0;
  logic [NUM_CH-1:0] ack    = '0;
  logic [NUM_CH-1:0] reqOut;
  logic              anyReq;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    modelReady = 1'b0;
  bit    finished = 1'b0;

  always #10 clk = ~clk;

  irqCapture #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) i_irqCapture (
    .clk    (clk),
    .rst    (rst),
    .reqIn  (reqIn),
    .bypass (bypass),
    .ack    (ack),
    .reqOut (reqOut),
    .anyReq (anyReq)
  );

  // Behavioural reference: a delay queue for the synchronizer, then the rules.
  logic [NUM_CH-1:0] syncQ [$];
  logic [NUM_CH-1:0] mPrev, mCap, mOut;

  always @(posedge clk) begin
    logic [NUM_CH-1:0] sNow, risen, nOut;
    if (rst) begin
      syncQ.delete();
      for (int i = 0; i < SYNC_STAGES; i++) syncQ.push_back('0);
      mPrev = '0; mCap = '0; mOut = '0;
      modelReady = 1'b1;
    end else begin
      sNow  = syncQ[0];
      risen = sNow & ~mPrev;
      nOut  = (bypass & sNow) | (~bypass & mCap);
      mCap  = (risen | (mCap & ~ack)) & ~bypass;
      mOut  = nOut;
      mPrev = sNow;
      void'(syncQ.pop_front());
      syncQ.push_back(reqIn);
    end
  end

  task automatic check(string req, logic [NUM_CH-1:0] act, logic [NUM_CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (modelReady && !finished) begin
      check(curReq, reqOut, mOut);
      check("R8", {{(NUM_CH-1){1'b0}}, anyReq}, {{(NUM_CH-1){1'b0}}, (mOut != '0)});
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int ch);
    reqIn[ch] = 1'b1;
    tick(1);
    reqIn[ch] = 1'b0;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R1: reset state
    tick(3);
    rst = 1'b0;
    check("R1", reqOut, '0);

    // R2: level mode follows the line with fixed latency, ack ignored
    curReq = "R2";
    bypass = '1;
    tick(1);
    reqIn[0] = 1'b1;
    tick(2);
    check("R2", {7'b0, reqOut[0]}, 8'b0);
    tick(1);
    check("R2", {7'b0, reqOut[0]}, 8'b1);
    ack[0] = 1'b1; reqIn[3] = 1'b1;
    tick(4);
    check("R2", reqOut, 8'b0000_1001);
    ack[0] = 1'b0;
    reqIn = '0;
    tick(5);
    check("R2", reqOut, '0);

    // R3: single-cycle pulse caught and held
    curReq = "R3";
    bypass = '0;
    tick(2);
    pulse(1);
    tick(5);
    check("R3", reqOut, 8'b0000_0010);
    tick(5);
    check("R3", reqOut, 8'b0000_0010);

    // R4: repeated pulses merge, one ack clears
    curReq = "R4";
    pulse(1); tick(2); pulse(1);
    tick(5);
    check("R4", reqOut, 8'b0000_0010);
    ack[1] = 1'b1; tick(1); ack[1] = 1'b0;
    tick(4);
    check("R4", reqOut, '0);

    // R5: acknowledge latency
    curReq = "R5";
    pulse(2);
    tick(5);
    ack[2] = 1'b1;
    tick(1);
    ack[2] = 1'b0;
    check("R5", {7'b0, reqOut[2]}, 8'b1);
    tick(1);
    check("R5", {7'b0, reqOut[2]}, 8'b0);

    // R6: edge and ack in the same cycle
    curReq = "R6";
    pulse(4);
    tick(6);
    reqIn[4] = 1'b1;
    tick(2);
    ack[4] = 1'b1;
    tick(1);
    ack[4] = 1'b0; reqIn[4] = 1'b0;
    tick(4);
    check("R6", {7'b0, reqOut[4]}, 8'b1);

    // R7: level mode holds the latch clear
    curReq = "R7";
    pulse(5);
    tick(6);
    check("R7", {7'b0, reqOut[5]}, 8'b1);
    bypass[5] = 1'b1;
    tick(3);
    bypass[5] = 1'b0;
    tick(4);
    check("R7", {7'b0, reqOut[5]}, 8'b0);
    check("R9", {7'b0, reqOut[4]}, 8'b1);

    // R9: mixed random traffic across all channels
    curReq = "R9";
    for (int i = 0; i < 400; i++) begin
      if ((i % 23) == 0) bypass = NUM_CH'($urandom);
      reqIn = NUM_CH'($urandom) & NUM_CH'($urandom);
      ack   = NUM_CH'($urandom) & NUM_CH'($urandom) & NUM_CH'($urandom);
      tick(1);
    end
    reqIn = '0; ack = '0;

    // R1: reset in the middle of activity
    curReq = "R1";
    bypass = '0;
    pulse(6); pulse(7);
    tick(5);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    check("R1", reqOut, '0);
    tick(4);
    check("R1", reqOut, '0);

    finish();
  end

endmodule